// File: doc/BRIEF.md
# IQ Double-Data-Rate Receive Interface

This block receives a 14-bit two's complement converter bus that carries two interleaved channels on one source-synchronous clock. The word present at each rising edge belongs to the in-phase channel (I). The word present at the following falling edge belongs to the quadrature channel (Q). An over-range flag travels beside the data on a separate pin and is captured through the same double-rate path, so each channel gets its own over-range bit.

Capture follows a pipelined same-edge scheme. The rising-edge word is held back half a period so that it leaves the capture stage together with the falling-edge word of the same period, on one rising edge. The block then presents a registered I/Q pair with per-channel over-range flags and a valid strobe, all in the converter clock domain, which runs at 125 MHz. A synchronous active-high reset clears the pair and drops the strobe. After reset is released, the strobe rises once the first complete pair has been captured, and it then stays high.

Top module: `iq_ddr_rx`

## Requirements
- R1: The 14-bit word on `adc_data` at a rising edge of `clk` appears unchanged on `i_out`, as two's complement bits, after the next rising edge.
- R2: The 14-bit word on `adc_data` at the falling edge that follows that rising edge appears unchanged on `q_out` after the same next rising edge. The latency from the falling-edge capture to the output is exactly one rising edge.
- R3: `i_out` and `q_out` always change together on one rising edge, and they hold the I and Q words of the same clock period (rising edge first, then the falling edge after it).
- R4: `or_i` carries the level of `adc_ovr` at the rising edge, and `or_q` carries its level at the falling edge, with the same timing as `i_out` and `q_out`.
- R5: While `rst` is high at a rising edge, `i_out`, `q_out`, `or_i`, `or_q` and `pair_valid` are all 0 after that edge.
- R6: `pair_valid` is 0 after the first rising edge at which `rst` is low. It is 1 from the second such edge onward, and it stays 1 until `rst` is asserted again.
- R7: The data and flag inputs may change at any fixed offset after each clock edge, provided they are stable at the capturing edge. The captured values are the levels that were present at that edge.
- R8: The full code range passes bit for bit. This includes the most negative code 14'h2000 (-8192), the most positive code 14'h1FFF (8191), all-ones 14'h3FFF (-1) and zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source-synchronous converter clock; both edges capture data |
| rst | input | 1 | Synchronous active-high reset |
| adc_data | input | 14 | Interleaved sample bus: I at the rising edge, Q at the falling edge |
| adc_ovr | input | 1 | Over-range flag, interleaved like the data |
| i_out | output | 14 | In-phase sample of the aligned pair, two's complement |
| q_out | output | 14 | Quadrature sample of the aligned pair, two's complement |
| or_i | output | 1 | Over-range flag captured with the I sample |
| or_q | output | 1 | Over-range flag captured with the Q sample |
| pair_valid | output | 1 | High when the output pair holds a complete captured pair |

## Verification
The first stimulus is a counting ramp on I with its bitwise complement on Q. Every pair then differs from its neighbours and from its own partner, so a swapped edge, a one-period slip or a pair built from two periods shows up as a mismatch. A block of code extremes toggles every bit between the two edges and exposes stuck or crossed lanes and sign-bit errors. An over-range pattern that is high on only one edge at a time separates `or_i` from `or_q`. Runs at a short and at a long launch offset after each edge, together with a reset in mid-stream, show that capture depends only on the level at the sampling edge and that the strobe restarts correctly.

// File: rtl/iq_rx_pkg.sv
package iq_rx_pkg;

  // Width of a counter that must reach the value n.
  function automatic int ctr_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // True once the number of non-reset edges seen reaches the warm-up depth.
  function automatic logic pair_ready(input int unsigned seen, input int unsigned need);
    return seen >= need;
  endfunction

endpackage

// File: rtl/iq_ddr_lane.sv
module iq_ddr_lane (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic rise_o,
  output logic fall_o,
  output logic early_o,
  output logic late_o
);
  logic rise_q, fall_q, early_q, late_q;

  // First capture stage on the rising edge.
  always_ff @(posedge clk) begin
    if (rst) rise_q <= 1'b0;
    else     rise_q <= d;
  end

  // Capture stage on the falling edge.
  always_ff @(negedge clk) begin
    if (rst) fall_q <= 1'b0;
    else     fall_q <= d;
  end

  // Pipelined same-edge stage: both halves of one period leave on one rising edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      early_q <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      early_q <= rise_q;
      late_q  <= fall_q;
    end
  end

  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
  assign early_o = early_q;
  assign late_o  = late_q;
endmodule

// File: rtl/iq_ddr_capture.sv
module iq_ddr_capture #(
  parameter int LANES = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] d,
  output logic [LANES-1:0] rise_word,
  output logic [LANES-1:0] fall_word,
  output logic [LANES-1:0] early_word,
  output logic [LANES-1:0] late_word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    iq_ddr_lane u_lane (
      .clk     (clk),
      .rst     (rst),
      .d       (d[g]),
      .rise_o  (rise_word[g]),
      .fall_o  (fall_word[g]),
      .early_o (early_word[g]),
      .late_o  (late_word[g])
    );
  end
endmodule

// File: rtl/iq_valid_gen.sv
module iq_valid_gen #(
  parameter int WARMUP = 2
) (
  input  logic clk,
  input  logic rst,
  output logic primed,
  output logic valid
);
  import iq_rx_pkg::*;

  localparam int CW = ctr_width(WARMUP);
  localparam logic [CW-1:0] FULL = CW'(WARMUP);

  logic [CW-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst)                seen_q <= '0;
    else if (seen_q != FULL) seen_q <= seen_q + 1'b1;
  end

  assign primed = (seen_q != '0);
  assign valid  = pair_ready(32'(seen_q), 32'(WARMUP));

  // R5: the strobe drops after any reset edge
  a_r5_valid_clear: assert property (@(posedge clk) rst |=> !valid);
  // R6: once high, the strobe stays high until reset
  a_r6_valid_hold: assert property (@(posedge clk) disable iff (rst) valid |=> valid);
  // R6: the strobe never rises before a non-reset edge has primed the pipe
  a_r6_valid_after_prime: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(primed));
endmodule

// File: rtl/iq_ddr_rx.sv
module iq_ddr_rx #(
  parameter int DATA_W = 14,
  parameter int WARMUP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              adc_ovr,
  output logic [DATA_W-1:0] i_out,
  output logic [DATA_W-1:0] q_out,
  output logic              or_i,
  output logic              or_q,
  output logic              pair_valid
);
  localparam int LANES = DATA_W + 1;

  logic [LANES-1:0] rise_word, fall_word, early_word, late_word;
  logic             primed;

  // The flag rides as the top lane of the same capture path.
  iq_ddr_capture #(.LANES(LANES)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .d          ({adc_ovr, adc_data}),
    .rise_word  (rise_word),
    .fall_word  (fall_word),
    .early_word (early_word),
    .late_word  (late_word)
  );

  iq_valid_gen #(.WARMUP(WARMUP)) u_vld (
    .clk    (clk),
    .rst    (rst),
    .primed (primed),
    .valid  (pair_valid)
  );

  assign i_out = early_word[DATA_W-1:0];
  assign or_i  = early_word[DATA_W];
  assign q_out = late_word[DATA_W-1:0];
  assign or_q  = late_word[DATA_W];

  // R1, R4: the I half comes from the previous rising-edge capture
  a_r1_i_from_rise: assert property (@(posedge clk) disable iff (rst)
    primed |-> ({or_i, i_out} == $past(rise_word)));
  // R2, R3: the Q half comes from the falling-edge capture one rising edge earlier
  a_r2_q_from_fall: assert property (@(posedge clk) disable iff (rst)
    primed |-> ({or_q, q_out} == $past(fall_word)));
  // R5: all outputs cleared after a reset edge
  a_r5_out_clear: assert property (@(posedge clk)
    rst |=> (i_out == '0 && q_out == '0 && !or_i && !or_q));
endmodule

// File: tb/tb_iq_ddr_rx.sv
`timescale 1ns/1ps
module tb_iq_ddr_rx;
  localparam int W = 14;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] adc_data = '0;
  logic         adc_ovr = 1'b0;
  logic [W-1:0] i_out, q_out;
  logic         or_i, or_q, pair_valid;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  real skew = 1.0;

  always #5 clk = ~clk;

  iq_ddr_rx dut (
    .clk(clk), .rst(rst), .adc_data(adc_data), .adc_ovr(adc_ovr),
    .i_out(i_out), .q_out(q_out), .or_i(or_i), .or_q(or_q),
    .pair_valid(pair_valid)
  );

  // Behavioural reference: queues of captured halves, a count of live edges.
  logic [W:0] rise_q[$];
  logic [W:0] fall_q[$];
  int         live_edges = 0;
  logic [W:0] exp_i, exp_q;
  bit         exp_v = 0, exp_zero = 1, exp_data = 0;

  always @(posedge clk) begin
    if (rst) begin
      live_edges = 0;
      rise_q.delete();
      fall_q.delete();
      exp_zero = 1; exp_v = 0; exp_data = 0;
    end else begin
      live_edges++;
      exp_zero = 0;
      exp_v = (live_edges >= 2);
      exp_data = 0;
      if (rise_q.size() > 0 && fall_q.size() > 0) begin
        exp_i = rise_q.pop_front();
        exp_q = fall_q.pop_front();
        exp_data = exp_v;
      end
      rise_q.push_back({adc_ovr, adc_data});
    end
  end

  always @(negedge clk) begin
    if (live_edges > 0 && rise_q.size() > fall_q.size())
      fall_q.push_back({adc_ovr, adc_data});
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // Compare every clock, 3 ns after the rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (exp_zero) begin
        chk("R5 i_out", int'(i_out), 0);
        chk("R5 q_out", int'(q_out), 0);
        chk("R5 or", int'({or_i, or_q}), 0);
        chk("R5 valid", int'(pair_valid), 0);
      end else begin
        chk("R6 valid", int'(pair_valid), int'(exp_v));
        if (exp_data) begin
          chk("R1 R3 R7 R8 i_out", int'(i_out), int'(exp_i[W-1:0]));
          chk("R2 R3 R7 R8 q_out", int'(q_out), int'(exp_q[W-1:0]));
          chk("R4 or_i", int'(or_i), int'(exp_i[W]));
          chk("R4 or_q", int'(or_q), int'(exp_q[W]));
        end
      end
    end
  end

  // One period: I launched after the falling edge, Q launched after the rising edge.
  task automatic send(input logic [W-1:0] iv, input logic oi,
                      input logic [W-1:0] qv, input logic oq);
    @(negedge clk); #(skew);
    adc_data = iv; adc_ovr = oi;
    @(posedge clk); #(skew);
    adc_data = qv; adc_ovr = oq;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // Ramp with complemented Q (R1, R2, R3)
    for (int k = 0; k < 40; k++)
      send(W'(k * 37), 1'b0, ~W'(k * 37), 1'b0);
    // Code extremes (R8)
    for (int k = 0; k < 8; k++) begin
      send(14'h2000, 1'b0, 14'h1FFF, 1'b0);
      send(14'h3FFF, 1'b0, 14'h0000, 1'b0);
      send(14'h1FFF, 1'b0, 14'h2000, 1'b0);
    end
    // Over-range on one edge at a time (R4)
    for (int k = 0; k < 12; k++)
      send(W'(k), k[0], W'(100 + k), ~k[0]);
    // Long launch offset (R7)
    skew = 4.0;
    for (int k = 0; k < 30; k++)
      send(W'(k * 531 + 7), k[1], W'(k * 97 + 3), k[2]);
    skew = 1.0;
    // Mid-stream reset and restart (R5, R6)
    @(posedge clk); #1 rst = 1'b1;
    repeat (3) send(14'h0ABC, 1'b1, 14'h1555, 1'b1);
    @(posedge clk); #1 rst = 1'b0;
    for (int k = 0; k < 20; k++)
      send(W'(8000 - k * 411), k[0], W'(k * 811), k[1]);
    repeat (3) @(posedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule